// File: doc/BRIEF.md
# Two-Thread In-Order Issue Scheduler

This block is the issue stage that two hardware threads share in one in-order core. Each thread offers at most one pre-decoded instruction per cycle on its own valid/ready channel. The instruction carries a class, one destination register and two source registers. A round-robin arbiter picks which thread may fill the single integer-queue slot. That slot checks integer hazards and issues integer work to the integer pipe. It hands vector work on to a single vector-queue slot, which checks vector hazards and the occupancy of the estimate unit before issuing to the vector pipe.

Hazards are tracked with two scoreboards, one for integer registers and one for vector registers. Each scoreboard keeps a per-register countdown that is loaded when a producer issues. Both queue slots are shared by the two threads, so a stall at the head of the integer queue holds back both threads. A vector instruction that cannot move forward holds the integer queue as well. The countdown timers keep running while the queues are stalled, because the execution pipes behind the block never stop.

Back-pressure rules: `in_ready[t]` is high only in a cycle where thread t has `in_valid[t]` high, wins arbitration, and the integer slot is empty or empties in that cycle. A transfer takes place on the rising edge where valid and ready are both high. A thread whose valid is high must hold its instruction steady until that transfer.

Top module: `dual_thread_issue`

## Requirements
- R1: After reset both queue slots are empty and all scoreboard counts are zero. No issue strobe is asserted, and `in_ready` is 0 while no thread is valid.
- R2: Instruction word (17 bits with the default 5-bit register field): bits [16:15] hold the class, with 0 = integer, 1 = vector load/store, 2 = vector, 3 = estimate. Bits [14:10] hold the destination, [9:5] source A and [4:0] source B. At most one instruction is accepted per cycle, and only through a valid/ready handshake.
- R3: When both threads are valid in a cycle where the slot can load, the grant goes to the thread that did not receive the previous grant. Neither thread has fixed priority.
- R4: An instruction accepted at edge k sits in the integer slot during cycle k+1 and, with no hazard present, issues in that cycle. Two independent integer instructions from one stream therefore issue one cycle apart.
- R5: An integer instruction that reads the destination of an integer instruction issued in cycle c issues no earlier than cycle c+INT_LAT (default 2).
- R6: While the integer slot holds an instruction that cannot advance, both `in_ready` bits are 0, `iq_stall` is 1, and the slot contents stay unchanged.
- R7: A vector load/store is checked against the integer scoreboard for its sources, issues on the integer pipe, and marks no register busy.
- R8: Vector and estimate instructions leave the integer slot with no source check, moving into the vector slot when it is empty or issuing in that cycle. Otherwise the integer slot stalls.
- R9: A vector instruction that reads the destination of a vector instruction issued in cycle c issues no earlier than c+VEC_LAT (default 12), or c+EST_LAT (default 14) when the producer is an estimate.
- R10: Two estimate instructions issue at least EST_GAP (default 4) cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 2 | Per-thread instruction valid |
| in_ready | output | 2 | Per-thread accept |
| in_instr0 | input | 2+3*REG_W | Thread 0 instruction word |
| in_instr1 | input | 2+3*REG_W | Thread 1 instruction word |
| int_valid | output | 1 | Issue strobe to the integer pipe |
| int_tid | output | 1 | Thread of the integer issue |
| int_instr | output | 2+3*REG_W | Instruction issued to the integer pipe |
| vec_valid | output | 1 | Issue strobe to the vector pipe |
| vec_tid | output | 1 | Thread of the vector issue |
| vec_instr | output | 2+3*REG_W | Instruction issued to the vector pipe |
| iq_stall | output | 1 | Integer slot occupied and held |
| vq_stall | output | 1 | Vector slot occupied and held |

## Verification
Scripted streams cover several cases: independent integer runs, which separate single-issue spacing from hazard spacing, and dependent integer pairs, which expose the integer latency. Interleaved two-thread streams show whether arbitration alternates and whether a stall in one thread freezes the other. Dependent vector chains after a plain vector and after an estimate distinguish the two vector latencies. A blocked vector chain followed by a load/store and an integer instruction shows back-pressure into the integer slot, and also shows that a load/store marks nothing busy. Back-to-back estimates expose the structural gap.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    K_INT = 2'd0,
    K_VLS = 2'd1,
    K_VEC = 2'd2,
    K_EST = 2'd3
  } iclass_e;
endpackage

// File: rtl/sched_scoreboard.sv
module sched_scoreboard #(
  parameter int NREG = 32,
  parameter int CW   = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a,
  input  logic [AW-1:0] rd_b,
  output logic          srcs_free,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [CW-1:0] ld_val
);
  logic [CW-1:0] cnt_q [NREG];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (!rst_n)                                   cnt_q[i] <= '0;
      else if (ld_en && ld_addr == AW'(i))          cnt_q[i] <= ld_val;
      else if (cnt_q[i] != '0)                      cnt_q[i] <= cnt_q[i] - 1'b1;
    end
  end

  assign srcs_free = (cnt_q[rd_a] == '0) && (cnt_q[rd_b] == '0);

  // R5 / R9: a producer's latency is visible in the next cycle
  a_r9_load_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> cnt_q[$past(ld_addr)] == $past(ld_val));
endmodule

// File: rtl/sched_rr_arb.sv
module sched_rr_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic       en,
  output logic [1:0] gnt
);
  logic last_q;

  always_comb begin
    gnt = 2'b00;
    if (en) begin
      unique case (req)
        2'b01:   gnt = 2'b01;
        2'b10:   gnt = 2'b10;
        2'b11:   gnt = last_q ? 2'b01 : 2'b10;
        default: gnt = 2'b00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     last_q <= 1'b0;
    else if (|gnt)  last_q <= gnt[1];
  end

  a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == 2'b00));

  a_r3_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (en && req == 2'b11 && gnt == 2'b01) ##1 (en && req == 2'b11) |-> gnt == 2'b10);
endmodule

// File: rtl/dual_thread_issue.sv
module dual_thread_issue #(
  parameter int REG_W   = 5,
  parameter int INT_LAT = 2,
  parameter int VEC_LAT = 12,
  parameter int EST_LAT = 14,
  parameter int EST_GAP = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           in_valid,
  output logic [1:0]           in_ready,
  input  logic [2+3*REG_W-1:0] in_instr0,
  input  logic [2+3*REG_W-1:0] in_instr1,
  output logic                 int_valid,
  output logic                 int_tid,
  output logic [2+3*REG_W-1:0] int_instr,
  output logic                 vec_valid,
  output logic                 vec_tid,
  output logic [2+3*REG_W-1:0] vec_instr,
  output logic                 iq_stall,
  output logic                 vq_stall
);
  import sched_pkg::*;

  localparam int IW   = 2 + 3*REG_W;
  localparam int NREG = 1 << REG_W;
  localparam int L1   = (INT_LAT > VEC_LAT) ? INT_LAT : VEC_LAT;
  localparam int L2   = (L1 > EST_LAT) ? L1 : EST_LAT;
  localparam int LMAX = (L2 > EST_GAP) ? L2 : EST_GAP;
  localparam int CW   = $clog2(LMAX + 1);

  logic          iq_v, vq_v, iq_t, vq_t;
  logic [IW-1:0] iq_i, vq_i;
  logic [CW-1:0] est_q;
  iclass_e       iq_k, vq_k;
  logic          irdy, vrdy, iq_is_int, vq_go, vq_space, xfer, iq_adv, iq_space;
  logic [1:0]    gnt;

  assign iq_k = iclass_e'(iq_i[IW-1:IW-2]);
  assign vq_k = iclass_e'(vq_i[IW-1:IW-2]);

  sched_scoreboard #(.NREG(NREG), .CW(CW)) i_int_sb (
    .clk(clk), .rst_n(rst_n),
    .rd_a(iq_i[2*REG_W-1:REG_W]), .rd_b(iq_i[REG_W-1:0]), .srcs_free(irdy),
    .ld_en(int_valid && iq_k == K_INT), .ld_addr(iq_i[3*REG_W-1:2*REG_W]),
    .ld_val(CW'(INT_LAT - 1)));

  sched_scoreboard #(.NREG(NREG), .CW(CW)) i_vec_sb (
    .clk(clk), .rst_n(rst_n),
    .rd_a(vq_i[2*REG_W-1:REG_W]), .rd_b(vq_i[REG_W-1:0]), .srcs_free(vrdy),
    .ld_en(vq_go), .ld_addr(vq_i[3*REG_W-1:2*REG_W]),
    .ld_val((vq_k == K_EST) ? CW'(EST_LAT - 1) : CW'(VEC_LAT - 1)));

  assign iq_is_int = (iq_k == K_INT) || (iq_k == K_VLS);
  assign vq_go     = vq_v && vrdy && (vq_k != K_EST || est_q == '0);
  assign vq_space  = !vq_v || vq_go;
  assign int_valid = iq_v && iq_is_int && irdy;
  assign xfer      = iq_v && !iq_is_int && vq_space;
  assign iq_adv    = int_valid || xfer;
  assign iq_space  = !iq_v || iq_adv;

  sched_rr_arb i_arb (.clk(clk), .rst_n(rst_n), .req(in_valid), .en(iq_space), .gnt(gnt));

  assign in_ready  = gnt;
  assign int_tid   = iq_t;
  assign int_instr = iq_i;
  assign vec_valid = vq_go;
  assign vec_tid   = vq_t;
  assign vec_instr = vq_i;
  assign iq_stall  = iq_v && !iq_adv;
  assign vq_stall  = vq_v && !vq_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iq_v <= 1'b0; iq_t <= 1'b0; iq_i <= '0;
    end else if (|gnt) begin
      iq_v <= 1'b1; iq_t <= gnt[1]; iq_i <= gnt[1] ? in_instr1 : in_instr0;
    end else if (iq_adv) begin
      iq_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vq_v <= 1'b0; vq_t <= 1'b0; vq_i <= '0;
    end else if (xfer) begin
      vq_v <= 1'b1; vq_t <= iq_t; vq_i <= iq_i;
    end else if (vq_go) begin
      vq_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     est_q <= '0;
    else if (vq_go && vq_k == K_EST) est_q <= CW'(EST_GAP - 1);
    else if (est_q != '0)           est_q <= est_q - 1'b1;
  end

  a_r6_hold_slot: assert property (@(posedge clk) disable iff (!rst_n)
    iq_stall |=> iq_v && iq_i == $past(iq_i) && iq_t == $past(iq_t));

  a_r6_freeze_both: assert property (@(posedge clk) disable iff (!rst_n)
    iq_stall |-> in_ready == 2'b00);

  a_r8_vq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    vq_stall |=> vq_v && $stable(vq_i));

  a_r8_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (iq_v && !iq_is_int && vq_stall) |=> iq_v && $stable(iq_i));

  generate
    if (INT_LAT > 1) begin : g_int_chk
      a_r5_no_early_use: assert property (@(posedge clk) disable iff (!rst_n)
        (int_valid && iq_k == K_INT) |=>
          !(int_valid && (iq_i[2*REG_W-1:REG_W] == $past(iq_i[3*REG_W-1:2*REG_W]) ||
                          iq_i[REG_W-1:0]       == $past(iq_i[3*REG_W-1:2*REG_W]))));
    end
    if (EST_GAP > 1) begin : g_est_chk
      a_r10_est_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vq_k == K_EST) |=> !(vec_valid && vq_k == K_EST));
    end
  endgenerate
endmodule

// File: tb/test_dual_thread_issue.sv
module test_dual_thread_issue;
  localparam int CLK_P = 10;
  localparam int RW = 5, IW = 17;
  localparam int IL = 2, VL = 12, EL = 14, EG = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] in_valid = 2'b00, in_ready;
  logic [IW-1:0] in_instr0 = '0, in_instr1 = '0, int_instr, vec_instr;
  logic int_valid, int_tid, vec_valid, vec_tid, iq_stall, vq_stall;

  always #(CLK_P/2) clk = ~clk;

  dual_thread_issue i_dual_thread_issue (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr0(in_instr0), .in_instr1(in_instr1),
    .int_valid(int_valid), .int_tid(int_tid), .int_instr(int_instr),
    .vec_valid(vec_valid), .vec_tid(vec_tid), .vec_instr(vec_instr),
    .iq_stall(iq_stall), .vq_stall(vq_stall));

  int checks = 0, fails = 0, cyc = 0;
  logic [IW-1:0] st0[$], st1[$];
  int int_cyc[$], vec_cyc[$];
  int int_thr[$];

  // behavioural reference state
  int sbi[32], sbv[32], est;
  bit iq_v, vq_v, iq_t, vq_t, rr;
  logic [IW-1:0] iq_i, vq_i;
  bit d_load, d_lt, d_iiss, d_xfer, d_viss;

  function automatic logic [IW-1:0] mk(int c, int d, int a, int b);
    return {c[1:0], d[4:0], a[4:0], b[4:0]};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model_update();
    for (int r = 0; r < 32; r++) begin
      if (sbi[r] > 0) sbi[r]--;
      if (sbv[r] > 0) sbv[r]--;
    end
    if (est > 0) est--;
    if (d_iiss && iq_i[16:15] == 2'd0) sbi[iq_i[14:10]] = IL - 1;
    if (d_viss) begin
      sbv[vq_i[14:10]] = (vq_i[16:15] == 2'd3) ? EL - 1 : VL - 1;
      if (vq_i[16:15] == 2'd3) est = EG - 1;
    end
    if (d_xfer) begin vq_v = 1; vq_i = iq_i; vq_t = iq_t; end
    else if (d_viss) vq_v = 0;
    if (d_load) begin
      iq_v = 1; iq_t = d_lt; rr = d_lt;
      if (d_lt) iq_i = st1.pop_front(); else iq_i = st0.pop_front();
    end else if (d_iiss || d_xfer) iq_v = 0;
  endtask

  task automatic model_step(string tag);
    bit isint, vspace, space, v0, v1;
    logic [1:0] g;
    d_viss = vq_v && sbv[vq_i[9:5]] == 0 && sbv[vq_i[4:0]] == 0 &&
             (vq_i[16:15] != 2'd3 || est == 0);
    vspace = !vq_v || d_viss;
    isint  = iq_i[16:15] < 2'd2;
    d_iiss = iq_v && isint && sbi[iq_i[9:5]] == 0 && sbi[iq_i[4:0]] == 0;
    d_xfer = iq_v && !isint && vspace;
    space  = !iq_v || d_iiss || d_xfer;
    v0 = st0.size() > 0; v1 = st1.size() > 0;
    g = 2'b00;
    if (space) begin
      if (v0 && v1) g = rr ? 2'b01 : 2'b10;
      else if (v0)  g = 2'b01;
      else if (v1)  g = 2'b10;
    end
    d_load = |g; d_lt = g[1];
    check(in_ready == g, {tag, " R3 grant"}, in_ready, g);
    check(int_valid == d_iiss, {tag, " R5 int issue"}, int_valid, d_iiss);
    if (int_valid && d_iiss)
      check(int_instr == iq_i && int_tid == iq_t, {tag, " R4 int word"}, int_instr, iq_i);
    check(vec_valid == d_viss, {tag, " R9 vec issue"}, vec_valid, d_viss);
    if (vec_valid && d_viss)
      check(vec_instr == vq_i && vec_tid == vq_t, {tag, " R8 vec word"}, vec_instr, vq_i);
    check(iq_stall == (iq_v && !(d_iiss || d_xfer)), {tag, " R6 iq_stall"}, iq_stall, 0);
  endtask

  task automatic run(string tag, int n);
    int_cyc.delete(); vec_cyc.delete(); int_thr.delete();
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      cyc++;
      model_update();
      in_valid  = {st1.size() > 0, st0.size() > 0};
      in_instr0 = (st0.size() > 0) ? st0[0] : '0;
      in_instr1 = (st1.size() > 0) ? st1[0] : '0;
      #1;
      model_step(tag);
      if (int_valid) begin int_cyc.push_back(cyc); int_thr.push_back(int_tid); end
      if (vec_valid) vec_cyc.push_back(cyc);
    end
  endtask

  task automatic gap(string tag, int q[$], int i, int exp);
    if (q.size() > i) check(q[i] - q[i-1] == exp, tag, q[i] - q[i-1], exp);
    else check(0, {tag, " missing issue"}, q.size(), i + 1);
  endtask

  initial begin
    #(CLK_P * 20000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < 32; r++) begin sbi[r] = 0; sbv[r] = 0; end
    est = 0; iq_v = 0; vq_v = 0; iq_t = 0; vq_t = 0; rr = 0; iq_i = '0; vq_i = '0;
    d_load = 0; d_lt = 0; d_iiss = 0; d_xfer = 0; d_viss = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    check(in_ready == 2'b00 && !int_valid && !vec_valid && !iq_stall && !vq_stall,
          "R1 reset idle", {in_ready, int_valid, vec_valid}, 0);

    // R4: independent integer run
    st0 = '{mk(0,1,2,3), mk(0,4,5,6), mk(0,7,8,9)};
    run("S1", 12);
    gap("R4 independent spacing", int_cyc, 1, 1);
    gap("R4 independent spacing", int_cyc, 2, 1);

    // R5: dependent integer pair
    st0 = '{mk(0,1,2,3), mk(0,5,1,1)};
    run("S2", 12);
    gap("R5 dependent spacing", int_cyc, 1, IL);

    // R3, R6: two threads interleaved, thread 0 has a dependency
    st0 = '{mk(0,10,11,12), mk(0,16,10,10)};
    st1 = '{mk(0,13,14,15), mk(0,17,18,19)};
    run("S3", 14);
    if (int_thr.size() >= 2)
      check(int_thr[0] != int_thr[1], "R3 alternation", int_thr[1], !int_thr[0]);
    else check(0, "R3 missing issue", int_thr.size(), 2);

    // R9: vector chains after plain vector and after estimate
    st1 = '{mk(2,1,2,3), mk(2,4,1,1), mk(3,6,7,7), mk(2,8,6,6)};
    run("S4", 45);
    gap("R9 vector latency", vec_cyc, 1, VL);
    gap("R9 estimate latency", vec_cyc, 3, EL);

    // R7, R8: blocked vectors back-pressure a load/store and an integer op
    st0 = '{mk(2,1,2,2), mk(2,3,1,1), mk(2,9,9,9), mk(1,24,20,21), mk(0,22,24,24)};
    run("S5", 30);
    if (int_cyc.size() > 0 && vec_cyc.size() > 1)
      check(int_cyc[0] == vec_cyc[1] + 1, "R8 backpressure", int_cyc[0], vec_cyc[1] + 1);
    else check(0, "R8 missing issue", int_cyc.size(), 1);
    gap("R7 load/store marks nothing", int_cyc, 1, 1);

    // R10: back-to-back independent estimates
    st1 = '{mk(3,10,11,11), mk(3,12,13,13)};
    run("S6", 14);
    gap("R10 estimate gap", vec_cyc, 1, EG);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule